// File: doc/BRIEF.md
# Scanline Indirection Video Address Generator

This block turns a per-line lookup table in RAM into the byte address of every visible pixel in a frame. Each displayed line has a table entry of two bytes. One byte picks the RAM page that holds the line's pixels. The other byte is a horizontal delta. The block adds each line's delta to a running total that it carries from line to line. The new total is the line's starting low byte, so changing one delta moves that line and every line after it.

A frame-start strobe clears the running total and the line counter. A line-start strobe makes the block read both bytes of the current line's entry over a synchronous RAM read port with a fixed latency of one cycle. It then walks 160 consecutive bytes in the selected page, stepping once per pixel-enable. The pixel address and a valid flag drive the pixel-fetch path. After the last line the block stays idle until the next frame begins.

Top module: `scanline_addr_gen`

## Requirements
- R1: Line n (0 to 119) has its table entry at address 0x0100 + 2n. Every table read falls inside the range 0x0100 to 0x01EF.
- R2: An accepted line-start strobe produces exactly two reads on consecutive cycles: the even address first, then the odd one. No read happens while pixel_valid is high. With one cycle of read latency, pixel_valid rises three cycles after the clock edge that samples the strobe.
- R3: For all pixels of a line, the high byte of pixel_addr equals the even (page) byte of that line's entry.
- R4: The first pixel's low byte equals the sum, modulo 256, of the odd (delta) bytes of lines 0 through the current line.
- R5: Frame-start clears the running sum to zero and sets the next line to 0. A later frame therefore recomputes every start from the current table contents.
- R6: The low byte wraps from 0xFF to 0x00 and never carries into the high byte.
- R7: The pixel address rises by one on each clock where pixel_en is high during a line and holds otherwise. After exactly 160 such steps, pixel_valid falls.
- R8: pixel_valid is low after reset, between lines and while table bytes are being fetched.
- R9: Before the first frame-start and after line 119, line-start strobes cause no reads and no pixels until the next frame-start.
- R10: A line-start strobe that arrives while a line is being fetched or walked is ignored. It causes no reads and does not disturb the pixel sequence.
- R11: Lines whose entries name the same page and the same start produce identical address sequences.
- R12: A frame-start in the middle of a line drops that line at once (no valid pixel on the next cycle) and restarts the frame at line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that begins a frame |
| line_start | input | 1 | One-cycle strobe that begins the next line |
| pixel_en | input | 1 | Advance to the next pixel byte |
| mem_rd | output | 1 | Table read request |
| mem_raddr | output | 16 | Table read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| pixel_addr | output | 16 | Page and low byte of the current pixel |
| pixel_valid | output | 1 | High while a line pixel is addressed |

## Verification
The assertions assume two things about the RAM: it returns data exactly one cycle after each request, and the strobes last one cycle. Under those assumptions the return order follows the request order, and frame-start is the only event that can cut a line short. The stimulus drives both strobes as single-cycle pulses on the falling edge. Its RAM model answers every request on the following rising edge. pixel_en is raised only in patterns that have gaps, so holding and stepping are both covered. Stray line-start pulses are sent during a walk and after the last line, and each time the bench confirms that no extra read appears.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    CS_HALT  = 2'd0,
    CS_IDLE  = 2'd1,
    CS_FETCH = 2'd2,
    CS_WALK  = 2'd3
  } ctl_state_t;

  // Address of the page byte of a line's entry; the delta byte follows it.
  function automatic logic [15:0] entry_addr(input logic [15:0] base, input logic [15:0] line);
    return base + (line << 1);
  endfunction

  // Running horizontal start: modulo-256 accumulation.
  function automatic logic [7:0] wrap_add(input logic [7:0] a, input logic [7:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/sag_table_reader.sv
module sag_table_reader #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 7,
  parameter int RD_LAT = 1,
  parameter logic [AW-1:0] TABLE_BASE = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          start,
  input  logic [LW-1:0] line_idx,
  output logic          mem_rd,
  output logic [AW-1:0] mem_raddr,
  output logic          page_wr,
  output logic          delta_wr
);
  import sag_pkg::*;

  logic          issue_even_q, issue_odd_q;
  logic [AW-1:0] addr_q;
  logic [RD_LAT-1:0] tag_v_q, tag_odd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      issue_even_q <= 1'b0;
      issue_odd_q  <= 1'b0;
      addr_q       <= TABLE_BASE;
    end else begin
      issue_even_q <= start;
      issue_odd_q  <= issue_even_q;
      if (start)
        addr_q <= entry_addr(TABLE_BASE, 16'(line_idx));
      else if (issue_even_q)
        addr_q <= addr_q + AW'(1);
    end
  end

  // Tag pipeline mirrors the RAM latency so returns are labelled page/delta.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      tag_v_q   <= '0;
      tag_odd_q <= '0;
    end else begin
      tag_v_q[0]   <= issue_even_q | issue_odd_q;
      tag_odd_q[0] <= issue_odd_q;
      for (int i = 1; i < RD_LAT; i++) begin
        tag_v_q[i]   <= tag_v_q[i-1];
        tag_odd_q[i] <= tag_odd_q[i-1];
      end
    end
  end

  assign mem_rd    = issue_even_q | issue_odd_q;
  assign mem_raddr = addr_q;
  assign page_wr   = tag_v_q[RD_LAT-1] & ~tag_odd_q[RD_LAT-1];
  assign delta_wr  = tag_v_q[RD_LAT-1] &  tag_odd_q[RD_LAT-1];

  AST_ODD_FOLLOWS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_raddr[0] && !flush) |=> (mem_rd && mem_raddr[0] && mem_raddr == $past(mem_raddr) + AW'(1))); // R2
  AST_DELTA_AFTER_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (page_wr && !flush) |=> delta_wr); // R2
endmodule

// File: rtl/sag_hsum.sv
module sag_hsum #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          add_en,
  input  logic [DW-1:0] delta,
  output logic [DW-1:0] next_start
);
  import sag_pkg::*;

  logic [DW-1:0] sum_q;

  assign next_start = wrap_add(sum_q, delta);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) sum_q <= '0;
    else if (add_en)     sum_q <= next_start;
  end

  AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sum_q == '0)); // R5
endmodule

// File: rtl/sag_pixel_walker.sv
module sag_pixel_walker #(
  parameter int DW = 8,
  parameter int PIXELS = 160
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          page_wr,
  input  logic [DW-1:0] page_in,
  input  logic          go,
  input  logic [DW-1:0] low_in,
  input  logic          step,
  output logic [2*DW-1:0] pix_addr,
  output logic          pix_valid,
  output logic          line_end
);
  localparam int CW = $clog2(PIXELS);

  logic [DW-1:0] page_q, low_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;

  assign line_end  = valid_q & step & (cnt_q == CW'(PIXELS - 1));
  assign pix_addr  = {page_q, low_q};
  assign pix_valid = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      low_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (abort) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (page_wr) page_q <= page_in;
      if (go) begin
        low_q   <= low_in;
        cnt_q   <= '0;
        valid_q <= 1'b1;
      end else if (valid_q && step) begin
        low_q <= low_q + DW'(1);
        if (line_end) valid_q <= 1'b0;
        else          cnt_q   <= cnt_q + CW'(1);
      end
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && step && !line_end && !abort) |=>
      (pix_valid && pix_addr[DW-1:0] == $past(pix_addr[DW-1:0]) + DW'(1))); // R7
  AST_HOLD_IDLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !step && !abort) |=> (pix_valid && $stable(pix_addr))); // R7
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |-> $stable(pix_addr[2*DW-1:DW])); // R6
  AST_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> !pix_valid); // R7
endmodule

// File: rtl/scanline_addr_gen.sv
module scanline_addr_gen #(
  parameter int DW = 8,
  parameter int LINES = 120,
  parameter int PIXELS = 160,
  parameter int RD_LAT = 1,
  parameter logic [2*DW-1:0] TABLE_BASE = 16'h0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            line_start,
  input  logic            pixel_en,
  output logic            mem_rd,
  output logic [2*DW-1:0] mem_raddr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] pixel_addr,
  output logic            pixel_valid
);
  import sag_pkg::*;

  localparam int AW = 2 * DW;
  localparam int LW = $clog2(LINES);
  localparam logic [AW-1:0] TABLE_LAST = TABLE_BASE + AW'(2 * LINES - 1);

  ctl_state_t    st_q;
  logic [LW-1:0] line_q;
  logic          accept, page_wr, delta_wr, line_end, go;
  logic [DW-1:0] next_start;

  assign accept = (st_q == CS_IDLE) && line_start && !frame_start;
  assign go     = delta_wr && !frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CS_HALT;
      line_q <= '0;
    end else if (frame_start) begin
      st_q   <= CS_IDLE;
      line_q <= '0;
    end else begin
      unique case (st_q)
        CS_IDLE:  if (accept) st_q <= CS_FETCH;
        CS_FETCH: if (go)     st_q <= CS_WALK;
        CS_WALK:  if (line_end) begin
          st_q   <= (line_q == LW'(LINES - 1)) ? CS_HALT : CS_IDLE;
          line_q <= line_q + LW'(1);
        end
        default:  st_q <= CS_HALT;
      endcase
    end
  end

  sag_table_reader #(.AW(AW), .DW(DW), .LW(LW), .RD_LAT(RD_LAT), .TABLE_BASE(TABLE_BASE)) u_reader (
    .clk(clk), .rst_n(rst_n), .flush(frame_start), .start(accept), .line_idx(line_q),
    .mem_rd(mem_rd), .mem_raddr(mem_raddr), .page_wr(page_wr), .delta_wr(delta_wr)
  );

  sag_hsum #(.DW(DW)) u_hsum (
    .clk(clk), .rst_n(rst_n), .clear(frame_start), .add_en(go),
    .delta(mem_rdata), .next_start(next_start)
  );

  sag_pixel_walker #(.DW(DW), .PIXELS(PIXELS)) u_walker (
    .clk(clk), .rst_n(rst_n), .abort(frame_start), .page_wr(page_wr), .page_in(mem_rdata),
    .go(go), .low_in(next_start), .step(pixel_en),
    .pix_addr(pixel_addr), .pix_valid(pixel_valid), .line_end(line_end)
  );

  AST_TABLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_raddr >= TABLE_BASE && mem_raddr <= TABLE_LAST)); // R1
  AST_NO_READ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_valid |-> !mem_rd); // R2
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_HALT) |-> (!mem_rd && !pixel_valid)); // R9
  AST_VALID_ONLY_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_valid |-> (st_q == CS_WALK)); // R8
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!pixel_valid && !mem_rd && line_q == '0)); // R12
endmodule

// File: tb/scanline_addr_gen_test.sv
module scanline_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic        line_start = 1'b0;
  logic        pixel_en = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_raddr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] pixel_addr;
  logic        pixel_valid;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [15:0] rd_a0 = 16'h0, rd_a1 = 16'h0;
  logic [7:0] tbl [0:255];
  logic [7:0] exp_sum;
  int tick = 0;

  always #2 clk = ~clk;

  scanline_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .pixel_en(pixel_en), .mem_rd(mem_rd), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .pixel_addr(pixel_addr), .pixel_valid(pixel_valid)
  );

  // RAM model: one cycle of read latency; table page only.
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= (mem_raddr[15:8] == 8'h01) ? tbl[mem_raddr[7:0]] : 8'hEE;
      rd_cnt <= rd_cnt + 1;
      rd_a0 <= rd_a1;
      rd_a1 <= mem_raddr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_table(input int salt);
    for (int n = 0; n < 120; n++) begin
      // page: pairs of lines share a page; every fifth line uses page 0x08
      tbl[2*n]   = (n % 5 == 0) ? 8'h08 : 8'(8'h10 + n / 2);
      tbl[2*n+1] = (n == 0) ? 8'hF0 : 8'((n * 37 + salt) % 256);
    end
    tbl[2*7+1] = 8'h00;  // line 7 shares page and start with line 6 (R11)
    tbl[2*6] = 8'h33; tbl[2*7] = 8'h33;
  endtask

  task automatic begin_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    exp_sum = 8'h00;
    check("R12 valid low after frame start", 32'(pixel_valid), 32'd0);
  endtask

  // Runs one line and checks fetch, page, start, stepping and end.
  task automatic run_line(input int n, input bit poke);
    int k, rc0;
    logic [7:0] pg, st;
    logic [15:0] first;
    pg = tbl[2*n];
    exp_sum = exp_sum + tbl[2*n+1];
    st = exp_sum;
    rc0 = rd_cnt;
    line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 no valid during fetch", 32'(pixel_valid), 32'd0);
    @(negedge clk);
    check("R2 valid three cycles after strobe", 32'(pixel_valid), 32'd1);
    check("R2 two reads", 32'(rd_cnt - rc0), 32'd2);
    check("R1 even address", 32'(rd_a0), 32'(16'h0100 + 2 * n));
    check("R1 odd address", 32'(rd_a1), 32'(16'h0101 + 2 * n));
    first = pixel_addr;
    k = 0;
    while (k < 160) begin
      check("R3 page byte", 32'(pixel_addr[15:8]), 32'(pg));
      check("R4 R6 low byte", 32'(pixel_addr[7:0]), 32'(8'(st + k)));
      check("R7 valid", 32'(pixel_valid), 32'd1);
      pixel_en = ((tick % 7) != 3);
      line_start = poke && (k == 50);
      tick++;
      @(negedge clk);
      line_start = 1'b0;
      if (pixel_en) k++;
    end
    pixel_en = 1'b0;
    check("R7 valid falls after 160", 32'(pixel_valid), 32'd0);
    if (poke) check("R10 stray strobe ignored", 32'(rd_cnt - rc0), 32'd2);
    if (n == 7) check("R11 shared page and start", 32'(first), 32'({8'h33, 8'(st)}));
  endtask

  task automatic run_frame(input int poke_line);
    begin_frame();
    for (int n = 0; n < 120; n++) run_line(n, n == poke_line);
  endtask

  task automatic expect_quiet(input string req);
    int rc0;
    rc0 = rd_cnt;
    line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (6) @(negedge clk);
    check(req, 32'(rd_cnt - rc0), 32'd0);
    check(req, 32'(pixel_valid), 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset valid", 32'(pixel_valid), 32'd0);
    check("R9 reset no read", 32'(mem_rd), 32'd0);
    expect_quiet("R9 before first frame");
  endtask

  task automatic t_abort();
    begin_frame();
    line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (3) @(negedge clk);
    pixel_en = 1'b1;
    repeat (20) @(negedge clk);
    pixel_en = 1'b0;
    check("R12 mid-line valid", 32'(pixel_valid), 32'd1);
    frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    check("R12 line dropped", 32'(pixel_valid), 32'd0);
    exp_sum = 8'h00;
    run_line(0, 1'b0);
    run_line(1, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fill_table(11);
    t_reset();
    run_frame(40);
    expect_quiet("R9 after line 119");
    tbl[2*3+1] = 8'h55;  // change one delta: lines 3.. shift, sum restarts (R5)
    run_frame(-1);
    expect_quiet("R9 after second frame");
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule